// File: doc/BRIEF.md
# Three-Bit Bidirectional Shift Register

This block is a small register whose contents move one place toward either end on each rising clock edge. A 2-bit mode input chooses the action. The register can clear to zero, shift toward the least significant end, shift toward the most significant end, or keep its value. Two serial inputs supply the bit that enters the freed position. One serves shifts toward the LSB and the other serves shifts toward the MSB.

All bits of the register are driven straight onto a parallel output. Used as a serial-to-parallel converter, a stream is shifted in from one side for as many cycles as the register has bits. The whole word can then be read at once. The width is a parameter with a default of three. Reset is synchronous and active low.

Top module: `bidir_shreg3`

## Requirements
- R1: When `rst_n` is low at a rising edge of `clk`, `q` becomes all zeros on that edge, whatever the mode.
- R2: Mode code 2'b00 clears every bit of `q` to zero on the rising edge.
- R3: Mode code 2'b01 is a right shift. Each bit takes the value of the next more significant bit, and the MSB takes `ser_in_msb`. `ser_in_lsb` has no effect.
- R4: Mode code 2'b10 is a left shift. Each bit takes the value of the next less significant bit, and the LSB takes `ser_in_lsb`. `ser_in_msb` has no effect.
- R5: Mode code 2'b11 keeps `q` unchanged, and both serial inputs have no effect.
- R6: `q` changes only at a rising edge of `clk`. If `mode` or the serial inputs change between edges, `q` does not move until the next edge.
- R7: After three right shifts of the bits 1, 1, 0 in that order, `q` reads 3'b011. After three left shifts of 1, 0, 0, `q` reads 3'b100. In each case the first bit shifted in ends at the far end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all actions occur on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 2 | Action select: 00 clear, 01 right shift, 10 left shift, 11 hold |
| ser_in_msb | input | 1 | Bit entering the MSB on a right shift |
| ser_in_lsb | input | 1 | Bit entering the LSB on a left shift |
| q | output | WIDTH (3) | Parallel view of the register |

## Verification
Directed sequences shift fixed serial patterns through in each direction. These show that the entry end and the direction of travel are right, and that no bit is reversed. Clear and hold are applied with both serial inputs set to one. A wrong mode decode, or a serial input leaking into the wrong mode, then shows up as changed bits. A long seeded random run mixes all four codes with random serial bits, so every pair of consecutive modes is tried. Inputs are also changed halfway through each cycle, and the output is checked before the next edge, which separates edge-triggered updates from level-sensitive ones.

// File: rtl/shreg_pkg.sv
// Shared types for the bidirectional shift register.
// Assumes the 2-bit mode code layout given in the brief.
package shreg_pkg;

    typedef enum logic [1:0] {
        MODE_CLEAR = 2'b00,
        MODE_RIGHT = 2'b01,
        MODE_LEFT  = 2'b10,
        MODE_HOLD  = 2'b11
    } shreg_mode_e;

    // One strobe per action; exactly one is set for any defined code.
    typedef struct packed {
        logic clr;
        logic shr;
        logic shl;
        logic hld;
    } shreg_ctl_t;

endpackage

// File: rtl/shreg_mode_dec.sv
// Turns the raw 2-bit mode code into one strobe per action.
// Assumes the code is known; an unknown code asserts no strobe.
module shreg_mode_dec
    import shreg_pkg::*;
(
    input  logic [1:0] mode,
    output shreg_ctl_t ctl
);

    // Decode the mode code into action strobes.
    always_comb begin
        ctl = '0;
        case (shreg_mode_e'(mode))
            MODE_CLEAR: ctl.clr = 1'b1;
            MODE_RIGHT: ctl.shr = 1'b1;
            MODE_LEFT:  ctl.shl = 1'b1;
            MODE_HOLD:  ctl.hld = 1'b1;
            default:    ctl = '0;
        endcase
    end

endmodule

// File: rtl/shreg_bit_sel.sv
// Picks the next value of one register bit from the action strobes.
// Assumes the caller wires the upper neighbour (or the MSB serial
// input) to from_up and the lower neighbour (or the LSB serial input)
// to from_dn.
module shreg_bit_sel
    import shreg_pkg::*;
(
    input  shreg_ctl_t ctl,
    input  logic       cur,
    input  logic       from_up,
    input  logic       from_dn,
    output logic       nxt
);

    // Four-way selection of the next bit value.
    always_comb begin
        if (ctl.shr)      nxt = from_up;
        else if (ctl.shl) nxt = from_dn;
        else if (ctl.hld) nxt = cur;
        else              nxt = 1'b0;
    end

endmodule

// File: rtl/bidir_shreg3.sv
// Bidirectional shift register with a synchronous clear and a hold mode.
// Assumes WIDTH >= 2 and that rst_n is synchronous to clk.
module bidir_shreg3
    import shreg_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             ser_in_msb,
    input  logic             ser_in_lsb,
    output logic [WIDTH-1:0] q
);

    localparam int MSB = WIDTH - 1;

    shreg_ctl_t       ctl;
    logic [WIDTH-1:0] q_r;
    logic [WIDTH-1:0] q_nxt;

    shreg_mode_dec u_dec (
        .mode (mode),
        .ctl  (ctl)
    );

    // One selector per bit; the end bits take a serial input.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic up_src;
        logic dn_src;
        if (i == MSB) begin : g_top
            assign up_src = ser_in_msb;
        end else begin : g_mid_up
            assign up_src = q_r[i+1];
        end
        if (i == 0) begin : g_bot
            assign dn_src = ser_in_lsb;
        end else begin : g_mid_dn
            assign dn_src = q_r[i-1];
        end
        shreg_bit_sel u_sel (
            .ctl     (ctl),
            .cur     (q_r[i]),
            .from_up (up_src),
            .from_dn (dn_src),
            .nxt     (q_nxt[i])
        );
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nxt;
    end

    assign q = q_r;

    // R1: synchronous reset clears the register.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

    // R2: clear code empties the register.
    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (q == '0));

    // R3: right shift moves bits down, MSB from its serial input.
    a_r3_shift_right: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |=> (q == {$past(ser_in_msb), $past(q[MSB:1])}));

    // R4: left shift moves bits up, LSB from its serial input.
    a_r4_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> (q == {$past(q[MSB-1:0]), $past(ser_in_lsb)}));

    // R5: hold code leaves the register untouched.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |=> $stable(q));

endmodule

// File: tb/bidir_shreg3_tb_top.sv
module bidir_shreg3_tb_top;

    localparam int W = 3;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [1:0]   mode;
    logic         ser_in_msb;
    logic         ser_in_lsb;
    logic [W-1:0] q;

    int unsigned n_vec  = 0;
    int unsigned n_fail = 0;
    logic [W-1:0] exp_q;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bidir_shreg3 #(.WIDTH(W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .ser_in_msb (ser_in_msb),
        .ser_in_lsb (ser_in_lsb),
        .q          (q)
    );

    function automatic logic [W-1:0] model(input logic rn, input logic [1:0] m,
                                           input logic sm, input logic sl,
                                           input logic [W-1:0] cur);
        if (!rn) return '0;
        case (m)
            2'b00:   return '0;
            2'b01:   return {sm, cur[W-1:1]};
            2'b10:   return {cur[W-2:0], sl};
            default: return cur;
        endcase
    endfunction

    function automatic string req_of(input logic rn, input logic [1:0] m);
        if (!rn) return "R1";
        case (m)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] want);
        n_vec++;
        if (q !== want) begin
            n_fail++;
            $display("FAIL %s: q=%b expected %b", req, q, want);
        end
    endtask

    // One cycle: drive at falling edge, check R6 before the edge, check after.
    task automatic step(input logic rn, input logic [1:0] m, input logic sm, input logic sl);
        @(negedge clk);
        rst_n = rn; mode = m; ser_in_msb = sm; ser_in_lsb = sl;
        #2;
        check("R6", exp_q);
        exp_q = model(rn, m, sm, sl, exp_q);
        @(posedge clk);
        #1;
        check(req_of(rn, m), exp_q);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] tmp;
        rst_n = 1'b0; mode = 2'b11; ser_in_msb = 1'b1; ser_in_lsb = 1'b1;
        exp_q = '0;
        @(posedge clk); #1;
        check("R1", '0);
        step(1'b0, 2'b11, 1'b1, 1'b1);
        // R7 right-shift fill: 1,1,0 -> 011
        step(1'b1, 2'b01, 1'b1, 1'b0);
        step(1'b1, 2'b01, 1'b1, 1'b1);
        step(1'b1, 2'b01, 1'b0, 1'b1);
        check("R7", 3'b011);
        // R5 hold with serial inputs high
        step(1'b1, 2'b11, 1'b1, 1'b1);
        step(1'b1, 2'b11, 1'b0, 1'b0);
        // R2 clear with serial inputs high
        step(1'b1, 2'b00, 1'b1, 1'b1);
        // R7 left-shift fill: 1,0,0 -> 100
        step(1'b1, 2'b10, 1'b0, 1'b1);
        step(1'b1, 2'b10, 1'b1, 1'b0);
        step(1'b1, 2'b10, 1'b1, 1'b0);
        check("R7", 3'b100);
        // R1 reset while shifting
        step(1'b0, 2'b01, 1'b1, 1'b1);
        // Seeded random mix
        tmp = W'($urandom(32'd2024));
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r;
            r = $urandom;
            step((r[7:0] != 8'd0), r[9:8], r[10], r[11]);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule